// File: doc/BRIEF.md
# Conversion Channel Sequencer

This block supplies the channel configuration word that a converter front end uses for each conversion. A word carries a differential flag, a channel address, a polarity flag (bipolar when set), a gain flag and an end-of-loop marker. A two-bit mode selector picks where the word comes from:
- **Direct mode:** the word is taken straight from the configuration inputs.
- **Scan mode:** a counter sweeps every single-ended channel.
- **Run mode:** the word comes from a small program memory that loops up to its end-of-loop marker.
- **Program/readback mode:** strobes on the write or read line fill or walk that memory.

Each word leaves the block on a valid/ready stream. `cfg_valid` is high in every mode except program/readback. A handshake (`cfg_valid` and `cfg_ready` both high at a clock edge) tells the block that a conversion has started on that word, and the block then moves to the next one. While `cfg_ready` is low the block holds the word and does not move on; in direct mode the word also changes when the inputs are reloaded. The block also decodes each word into a positive and a negative input select for the analog multiplexer; select code 8 stands for the common input. Strobes, mode select and configuration inputs are sampled on the clock.

Top module: `chseq_top`

## Requirements
- R1: After reset, `busy_n`=1, `cfg_valid`=1, `cfg_word`=0, `rb_valid`=0, the pointer is at entry 0 and every memory entry reads 0.
- R2: The word layout is bit 6 differential, bits 5:3 channel address, bit 2 bipolar, bit 1 gain, bit 0 end-of-loop. The same layout applies to `cfg_word`, `rb_word` and the configuration inputs.
- R3: `mode_sel` is decoded as follows: 00 direct, 01 scan, 10 program/readback, 11 run. `busy_n` and `cfg_valid` go low at the first clock edge that samples 10, and return high at the first edge that samples another code.
- R4: In direct mode the inputs are captured at every edge where `wr_n` is low and are held while `wr_n` is high. Bit 0 of `cfg_word` reads 0 in this mode.
- R5: In program mode, an edge that samples `wr_n` high after it was low stores the inputs at the pointer entry and advances the pointer by one. The pointer wraps from entry 15 to entry 0.
- R6: In program mode, while `rd_n` is low, `rb_valid`=1 and `rb_word` shows the pointer entry. A rising `rd_n` advances the pointer.
- R7: In run mode `cfg_word` is the pointer entry. Each handshake advances the pointer. The pointer returns to 0 after an entry whose end-of-loop bit is set, and after entry 15.
- R8: In scan mode `cfg_word` = {0, count, bipolar, gain, 0}, where bipolar and gain come from the last direct-mode capture. The count advances by one on each handshake and wraps from 7 to 0.
- R9: Any change of `mode_sel` returns the pointer and the scan count to 0 at that edge.
- R10: `pos_sel` equals the word address. `neg_sel` is 8 for a single-ended word, or the address with bit 0 inverted for a differential word.
- R11: In scan and run modes, `cfg_word` holds steady while `cfg_valid` is high and `cfg_ready` is low. In program mode `cfg_ready` has no effect.
- R12: Write strobes outside program mode leave the memory unchanged, and `rb_valid` stays 0 outside program mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| mode_sel | input | 2 | operating mode code |
| wr_n | input | 1 | active-low write strobe |
| rd_n | input | 1 | active-low read strobe |
| in_diff | input | 1 | differential flag input |
| in_addr | input | 3 | channel address input |
| in_bip | input | 1 | bipolar flag input |
| in_gain | input | 1 | gain flag input |
| in_eos | input | 1 | end-of-loop flag input |
| busy_n | output | 1 | low while program/readback is active |
| cfg_valid | output | 1 | configuration word valid |
| cfg_ready | input | 1 | conversion engine takes the word |
| cfg_word | output | 7 | configuration word for the next conversion |
| pos_sel | output | 4 | positive multiplexer select |
| neg_sel | output | 4 | negative multiplexer select, 8 = common |
| rb_valid | output | 1 | readback word valid |
| rb_word | output | 7 | readback word, 0 when not valid |

## Verification
A pointer that has slipped by one shows up in readback: the first low read strobe returns the neighbouring entry. In run mode the same fault appears on the first handshake, as a wrong `cfg_word` and multiplexer selects. A missed wrap to entry 0 becomes visible one handshake after the end-of-loop entry. A scan count or pointer that is not cleared on a mode change is exposed on the first cycle after the new mode takes effect, since the expected word there is always entry 0 or channel 0.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_SCAN   = 2'b01,
    MODE_PROG   = 2'b10,
    MODE_RUN    = 2'b11
  } mode_e;

  // field offsets inside a configuration word
  localparam int unsigned EOS_BIT  = 0;
  localparam int unsigned GAIN_BIT = 1;
  localparam int unsigned BIP_BIT  = 2;
  localparam int unsigned ADDR_LSB = 3;
endpackage

// File: rtl/chseq_edge.sv
module chseq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign rise = strobe_n & ~prev_q;

  AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R5
endmodule

// File: rtl/chseq_store.sv
module chseq_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              adv,
  input  logic              to_zero,
  output logic [WORD_W-1:0] rdata,
  output logic [$clog2(DEPTH)-1:0] ptr
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_inc;

  assign ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign rdata   = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (wr_en) begin
      mem[ptr] <= wdata;
      ptr      <= ptr_inc;
    end else if (adv) begin
      ptr <= to_zero ? '0 : ptr_inc;
    end
  end

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0); // R9
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> ptr == (($past(ptr) == LAST) ? '0 : PTR_W'($past(ptr) + 1'b1))); // R5
  AST_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> mem[$past(ptr)] == $past(wdata)); // R5
  AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && to_zero && !wr_en && !clr) |=> ptr == '0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_en && !clr) |=> $stable(ptr)); // R11
endmodule

// File: rtl/chseq_scan.sv
module chseq_scan #(
  parameter int unsigned CH_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  output logic [CH_BITS-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> cnt == CH_BITS'($past(cnt) + 1'b1)); // R8
  AST_SCAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R9
endmodule

// File: rtl/chseq_top.sv
module chseq_top #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned CH_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic                 wr_n,
  input  logic                 rd_n,
  input  logic                 in_diff,
  input  logic [CH_BITS-1:0]   in_addr,
  input  logic                 in_bip,
  input  logic                 in_gain,
  input  logic                 in_eos,
  output logic                 busy_n,
  output logic                 cfg_valid,
  input  logic                 cfg_ready,
  output logic [CH_BITS+3:0]   cfg_word,
  output logic [CH_BITS:0]     pos_sel,
  output logic [CH_BITS:0]     neg_sel,
  output logic                 rb_valid,
  output logic [CH_BITS+3:0]   rb_word
);
  import chseq_pkg::*;

  localparam int unsigned WORD_W = CH_BITS + 4;
  localparam int unsigned PTR_W  = $clog2(DEPTH);
  localparam int unsigned DIFF_BIT = WORD_W - 1;
  localparam logic [CH_BITS:0] COMMON_SEL = (CH_BITS+1)'(1) << CH_BITS;

  mode_e             mode_q;
  logic              mode_chg;
  logic              in_prog;
  logic [1:0]        strb_n;
  logic [1:0]        strb_rise;
  logic              wr_rise, rd_rise;
  logic [WORD_W-1:0] cfg_in;
  logic [WORD_W-1:0] direct_q;
  logic [WORD_W-1:0] mem_word;
  logic [PTR_W-1:0]  ptr;
  logic [CH_BITS-1:0] scan_cnt;
  logic              hs;
  logic              st_wr, st_adv, st_zero;
  logic [CH_BITS-1:0] word_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_DIRECT;
    else        mode_q <= mode_e'(mode_sel);
  end

  assign mode_chg  = (mode_sel != mode_q);
  assign in_prog   = (mode_q == MODE_PROG);
  assign busy_n    = !in_prog;
  assign cfg_valid = !in_prog;
  assign hs        = cfg_valid && cfg_ready && !mode_chg;

  // strobe edge detection, index 0 write, index 1 read
  assign strb_n = {rd_n, wr_n};
  for (genvar g = 0; g < 2; g++) begin : g_strobe
    chseq_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (strb_n[g]),
      .rise     (strb_rise[g])
    );
  end
  assign wr_rise = strb_rise[0];
  assign rd_rise = strb_rise[1];

  assign cfg_in = {in_diff, in_addr, in_bip, in_gain, in_eos};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      direct_q <= '0;
    else if (mode_q == MODE_DIRECT && !mode_chg && !wr_n)
      direct_q <= cfg_in;
  end

  assign st_wr   = in_prog && wr_rise && !mode_chg;
  assign st_adv  = (in_prog && rd_rise && !mode_chg) || (mode_q == MODE_RUN && hs);
  assign st_zero = (mode_q == MODE_RUN) && hs && mem_word[EOS_BIT];

  chseq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (mode_chg),
    .wr_en   (st_wr),
    .wdata   (cfg_in),
    .adv     (st_adv),
    .to_zero (st_zero),
    .rdata   (mem_word),
    .ptr     (ptr)
  );

  chseq_scan #(.CH_BITS(CH_BITS)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mode_chg),
    .adv   (mode_q == MODE_SCAN && hs),
    .cnt   (scan_cnt)
  );

  always_comb begin
    unique case (mode_q)
      MODE_DIRECT: cfg_word = {direct_q[WORD_W-1:1], 1'b0};
      MODE_SCAN:   cfg_word = {1'b0, scan_cnt, direct_q[BIP_BIT], direct_q[GAIN_BIT], 1'b0};
      MODE_RUN:    cfg_word = mem_word;
      default:     cfg_word = '0;
    endcase
  end

  assign word_addr = cfg_word[ADDR_LSB +: CH_BITS];
  assign pos_sel   = {1'b0, word_addr};
  assign neg_sel   = cfg_word[DIFF_BIT] ? {1'b0, word_addr[CH_BITS-1:1], ~word_addr[0]}
                                        : COMMON_SEL;

  assign rb_valid = in_prog && !rd_n;
  assign rb_word  = rb_valid ? mem_word : '0;

  AST_BUSY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_PROG) |=> !busy_n); // R3
  AST_BUSY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != MODE_PROG) |=> busy_n); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready && mode_q != MODE_DIRECT && mode_sel == mode_q)
      |=> $stable(cfg_word)); // R11
  AST_RB_ONLY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != MODE_PROG) |=> !rb_valid); // R12
  AST_PAIR_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_sel != COMMON_SEL) |-> (neg_sel ^ pos_sel) == (CH_BITS+1)'(1)); // R10
endmodule

// File: tb/tb_chseq_top.sv
module tb_chseq_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       wr_n, rd_n;
  logic       in_diff, in_bip, in_gain, in_eos;
  logic [2:0] in_addr;
  logic       busy_n, cfg_valid, cfg_ready, rb_valid;
  logic [6:0] cfg_word, rb_word;
  logic [3:0] pos_sel, neg_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chseq_top dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_n(wr_n), .rd_n(rd_n),
    .in_diff(in_diff), .in_addr(in_addr), .in_bip(in_bip), .in_gain(in_gain),
    .in_eos(in_eos), .busy_n(busy_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .pos_sel(pos_sel), .neg_sel(neg_sel),
    .rb_valid(rb_valid), .rb_word(rb_word)
  );

  // {diff, addr, expected pos, expected neg}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 3'd0, 4'd0, 4'd8}, {1'b0, 3'd5, 4'd5, 4'd8},
    {1'b0, 3'd7, 4'd7, 4'd8}, {1'b1, 3'd0, 4'd0, 4'd1},
    {1'b1, 3'd1, 4'd1, 4'd0}, {1'b1, 3'd2, 4'd2, 4'd3},
    {1'b1, 3'd5, 4'd5, 4'd4}, {1'b1, 3'd6, 4'd6, 4'd7}
  };
  localparam logic [6:0] PW [4] = '{7'h4C, 7'h1A, 7'h77, 7'h28};

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_word(input logic [6:0] w);
    {in_diff, in_addr, in_bip, in_gain, in_eos} = w;
  endtask

  task automatic strobe_write(input logic [6:0] w);
    drive_word(w); wr_n = 1'b0; step();
    wr_n = 1'b1; step();
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_sel = m; step();
  endtask

  function automatic logic [6:0] ent(input int i);
    return {1'b0, 3'(i), 1'(i >> 3), 2'b00};
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; wr_n = 1'b1; rd_n = 1'b1; cfg_ready = 1'b0;
    drive_word(7'h00);
    repeat (3) step();
    rst_n = 1'b1; step(); #1;
    chk("R1 busy_n", busy_n, 1); chk("R1 cfg_valid", cfg_valid, 1);
    chk("R1 cfg_word", cfg_word, 0); chk("R1 rb_valid", rb_valid, 0);
    chk("R1 neg_sel", neg_sel, 8);

    // table walk in direct mode: capture, layout and decode
    for (int i = 0; i < 8; i++) begin
      {in_diff, in_addr} = VEC[i][11:8];
      in_bip = i[0]; in_gain = i[1]; in_eos = 1'b1;
      wr_n = 1'b0; step(); #1;
      chk("R4 R2 direct word", cfg_word, {VEC[i][11:8], i[0], i[1], 1'b0});
      chk("R10 pos_sel", pos_sel, VEC[i][7:4]);
      chk("R10 neg_sel", neg_sel, VEC[i][3:0]);
    end
    wr_n = 1'b1; step();
    drive_word(7'h7F); step(); #1;
    chk("R4 hold while wr_n high", cfg_word, 7'b1110110);

    // scan mode
    drive_word(7'b0000100); wr_n = 1'b0; step(); wr_n = 1'b1; step();
    set_mode(2'b01); #1;
    chk("R8 scan start", cfg_word, 7'h04);
    chk("R10 scan neg common", neg_sel, 8);
    cfg_ready = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      step(); #1;
      chk("R8 scan step", cfg_word, {1'b0, 3'(k % 8), 3'b100});
    end
    cfg_ready = 1'b0; step(); step(); #1;
    chk("R11 scan stall", cfg_word, {1'b0, 3'd1, 3'b100});

    // program
    set_mode(2'b10); #1;
    chk("R3 busy_n low", busy_n, 0); chk("R3 cfg_valid low", cfg_valid, 0);
    cfg_ready = 1'b1;
    for (int i = 0; i < 4; i++) strobe_write(PW[i]);
    cfg_ready = 1'b0;
    set_mode(2'b00); #1;
    chk("R3 busy_n released", busy_n, 1);
    set_mode(2'b10);
    for (int i = 0; i < 4; i++) begin
      rd_n = 1'b0; #1;
      chk("R6 rb_valid", rb_valid, 1);
      chk("R6 R5 R11 readback", rb_word, PW[i]);
      step(); rd_n = 1'b1; step();
    end
    rd_n = 1'b0; #1;
    chk("R1 R6 untouched entry", rb_word, 0);
    rd_n = 1'b1; step(); #1;
    chk("R6 rb_word idle", rb_word, 0);

    // run
    set_mode(2'b11); #1;
    chk("R7 run entry0", cfg_word, PW[0]);
    chk("R10 run pos", pos_sel, 1); chk("R10 run neg", neg_sel, 0);
    rd_n = 1'b0; #1;
    chk("R12 rb_valid outside prog", rb_valid, 0);
    rd_n = 1'b1; step(); step(); #1;
    chk("R11 run stall", cfg_word, PW[0]);
    cfg_ready = 1'b1;
    step(); #1; chk("R7 run entry1", cfg_word, PW[1]);
    step(); #1; chk("R7 run entry2", cfg_word, PW[2]);
    step(); #1; chk("R7 wrap at end-of-loop", cfg_word, PW[0]);
    cfg_ready = 1'b0;
    strobe_write(7'h38); #1;
    chk("R12 write ignored in run", cfg_word, PW[0]);
    set_mode(2'b10);
    rd_n = 1'b0; #1;
    chk("R12 memory intact", rb_word, PW[0]);
    rd_n = 1'b1; step();

    // fill all entries, check depth wrap
    set_mode(2'b00); set_mode(2'b10);
    for (int i = 0; i < 16; i++) strobe_write(ent(i));
    set_mode(2'b11); #1;
    chk("R9 run from entry0", cfg_word, ent(0));
    cfg_ready = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      step(); #1;
      chk("R7 depth walk", cfg_word, ent(i % 16));
    end
    step(); step(); cfg_ready = 1'b0;
    set_mode(2'b00); set_mode(2'b11); #1;
    chk("R9 pointer cleared on mode change", cfg_word, ent(0));

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule